// File: doc/BRIEF.md
# Register-Mapped Integer Divider

This block is a 32-bit integer divider that a processor drives through a small register bus. Software writes a dividend and a divisor, then reads back a quotient and a remainder once the status flag reports the divide complete. Two pairs of operand addresses exist. One pair treats the operands as unsigned. The other treats them as two's-complement. The address of the most recent operand write sets the signedness of the divide it starts.

The engine works on operand magnitudes. It produces one quotient bit per clock and corrects the signs of the quotient and the remainder in one last cycle. Both result registers can be written directly. A write to either one ends any divide in progress, so an operating system can restore a saved context. A dirty flag is raised by any write and cleared by reading the quotient. Software uses it to skip the save when no task has touched the divider since the last switch.

Top module: `intdiv_mmio`

## Requirements
- R1: After reset the status register reads ready=1 and dirty=0, and both the quotient and the remainder read 0.
- R2: Byte offsets: 0x60 unsigned dividend, 0x64 unsigned divisor, 0x68 signed dividend, 0x6C signed divisor, 0x70 quotient, 0x74 remainder, 0x78 status. The signedness of a divide is that of the operand address written last.
- R3: Each operand write starts a new divide at once and discards any divide in progress. Ready reads 0 for exactly WIDTH+1 cycles after the write edge, then reads 1.
- R4: In unsigned mode the quotient is floor(dividend/divisor) and the remainder is dividend modulo divisor.
- R5: In signed mode the quotient is truncated toward zero. The remainder is negative only when the dividend is negative. -2^31 divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: Division by zero completes in the normal time with remainder equal to the dividend. The quotient is all ones in unsigned mode. In signed mode it is -1 for a non-negative dividend and +1 for a negative dividend.
- R7: A write to the quotient or the remainder register stops any running divide and sets ready and dirty on the next cycle. The written value is kept, and the aborted divide does not overwrite it.
- R8: Dirty becomes 1 after a write to any of the six operand and result offsets. It becomes 0 after a read of the quotient. Reading the remainder leaves it unchanged.
- R9: The status register holds ready in bit 0 and dirty in bit 1, and bits 31:2 read 0. Writes to the status register change nothing.
- R10: Read data and its valid strobe appear on the cycle after the read request. Reads of any offset other than quotient, remainder or status return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | WIDTH | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The hardest case to reach is a divide that is interrupted partway through. The interruption can be a second operand write that must restart the engine under a different signedness, or a direct result write that must freeze the engine before its fix-up cycle stores a value. The stimulus issues the interrupting write a few cycles after the first operand write. It then waits well past the full divide latency and reads the results back, so that a stale completion would show up as a wrong value. The ready latency is measured exactly by reading the status register back to back after an operand write and counting the reads that return busy.

// File: rtl/intdiv_mmio.sv
module intdiv_mmio #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [ADDR_W-1:0] A_UDVD = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] A_UDVS = ADDR_W'('h64);
  localparam logic [ADDR_W-1:0] A_SDVD = ADDR_W'('h68);
  localparam logic [ADDR_W-1:0] A_SDVS = ADDR_W'('h6C);
  localparam logic [ADDR_W-1:0] A_QUO  = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] A_REM  = ADDR_W'('h74);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h78);

  logic [WIDTH-1:0] dvd, dvs, quo, rem, acc, qsh;
  logic             sgn, busy, dirty;
  logic [CW-1:0]    cnt;

  wire hit_dvd = bus_addr == A_UDVD || bus_addr == A_SDVD;
  wire hit_dvs = bus_addr == A_UDVS || bus_addr == A_SDVS;
  wire hit_sgn = bus_addr == A_SDVD || bus_addr == A_SDVS;
  wire wr_op   = bus_wr && (hit_dvd || hit_dvs);
  wire wr_quo  = bus_wr && bus_addr == A_QUO;
  wire wr_rem  = bus_wr && bus_addr == A_REM;
  wire wr_res  = wr_quo || wr_rem;
  wire rd_quo  = bus_rd && bus_addr == A_QUO;

  wire [WIDTH-1:0] dvd_n = hit_dvd ? bus_wdata : dvd;
  wire [WIDTH-1:0] dvs_n = hit_dvs ? bus_wdata : dvs;
  wire [WIDTH-1:0] dvd_mag = (hit_sgn && dvd_n[WIDTH-1]) ? -dvd_n : dvd_n;
  wire [WIDTH-1:0] dvs_mag = (sgn && dvs[WIDTH-1]) ? -dvs : dvs;

  wire [WIDTH:0] trial = {acc, qsh[WIDTH-1]};
  wire [WIDTH:0] diff  = trial - {1'b0, dvs_mag};
  wire           qbit  = !diff[WIDTH];

  wire neg_q = sgn && (dvd[WIDTH-1] ^ dvs[WIDTH-1]);
  wire neg_r = sgn && dvd[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd <= '0; dvs <= '0; sgn <= 1'b0;
      quo <= '0; rem <= '0; acc <= '0; qsh <= '0;
      busy <= 1'b0; cnt <= '0;
    end else if (wr_res) begin
      busy <= 1'b0;
      if (wr_quo) quo <= bus_wdata;
      if (wr_rem) rem <= bus_wdata;
    end else if (wr_op) begin
      dvd  <= dvd_n;
      dvs  <= dvs_n;
      sgn  <= hit_sgn;
      acc  <= '0;
      qsh  <= dvd_mag;
      cnt  <= CW'(WIDTH);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        acc <= qbit ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
        qsh <= {qsh[WIDTH-2:0], qbit};
        cnt <= cnt - 1'b1;
      end else begin
        quo  <= neg_q ? -qsh : qsh;
        rem  <= neg_r ? -acc : acc;
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty <= 1'b0;
    else if (wr_op || wr_res) dirty <= 1'b1;
    else if (rd_quo) dirty <= 1'b0;
  end

  logic [WIDTH-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_QUO) rd_mux = quo;
    else if (bus_addr == A_REM) rd_mux = rem;
    else if (bus_addr == A_STAT) rd_mux = {{(WIDTH-2){1'b0}}, dirty, !busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && !wr_res) |=> busy); // R3
  AST_RESULT_WRITE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_res |=> (!busy && dirty)); // R7
  AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_wr) |=> ($stable(quo) && $stable(rem))); // R7
  AST_QUO_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_quo && !bus_wr) |=> !dirty); // R8
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |=> bus_rdata[WIDTH-1:2] == '0); // R9
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != A_QUO && bus_addr != A_REM && bus_addr != A_STAT)
      |=> bus_rdata == '0); // R10
endmodule

// File: tb/tb_intdiv_mmio.sv
`timescale 1ns/1ps
module tb_intdiv_mmio;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  int checks = 0, fails = 0;
  bit finished = 0;

  intdiv_mmio #(.WIDTH(32), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid));

  always #10 clk = ~clk;

  // {signed, dividend, divisor, quotient, remainder}
  localparam logic [128:0] VEC [15] = '{
    {1'b0, 32'd100,        32'd7,          32'd14,         32'd2},
    {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    {1'b0, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF,   32'hF},
    {1'b0, 32'd5,          32'd9,          32'd0,          32'd5},
    {1'b0, 32'h80000000,   32'h80000000,   32'd1,          32'd0},
    {1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   32'd1},
    {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF},
    {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1},
    {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF},
    {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0},
    {1'b1, 32'hFFFFFF9C,   32'd10,         32'hFFFFFFF6,   32'd0},
    {1'b0, 32'd42,         32'd0,          32'hFFFFFFFF,   32'd42},
    {1'b1, 32'hFFFFFFFB,   32'd0,          32'd1,          32'hFFFFFFFB},
    {1'b1, 32'd5,          32'd0,          32'hFFFFFFFF,   32'd5},
    {1'b0, 32'hFFFFFFFB,   32'd0,          32'hFFFFFFFF,   32'hFFFFFFFB}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks are entered at a negedge and return at a negedge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wait_ready();
    logic [31:0] d; logic v;
    for (int i = 0; i < 100; i++) begin
      rd(8'h78, d, v);
      if (d[0]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d; logic v;
    int busy_reads;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 valid strobe and unmapped read
    rd(8'h78, d, v); chk("R1 status", d, 32'h1); chk("R10 rvalid", {31'b0, v}, 32'd1);
    rd(8'h70, d, v); chk("R1 quotient", d, 32'd0);
    rd(8'h74, d, v); chk("R1 remainder", d, 32'd0);
    wr(8'h60, 32'd123);
    wait_ready();
    rd(8'h60, d, v); chk("R10 operand offset reads 0", d, 32'd0);
    rd(8'h00, d, v); chk("R10 unmapped", d, 32'd0);
    idle(1); chk("R10 rvalid low", {31'b0, bus_rvalid}, 32'd0);

    // R2 R4 R5 R6 vector table
    foreach (VEC[i]) begin
      logic [128:0] e;
      e = VEC[i];
      wr(e[128] ? 8'h68 : 8'h60, e[127:96]);
      wr(e[128] ? 8'h6C : 8'h64, e[95:64]);
      wait_ready();
      rd(8'h70, d, v);
      chk(e[63:32] == 32'hFFFFFFFF && e[95:64] == 0 ? "R6 quotient" :
          (e[128] ? "R5 quotient" : "R4 quotient"), d, e[63:32]);
      rd(8'h74, d, v);
      chk(e[95:64] == 0 ? "R6 remainder" : (e[128] ? "R5 remainder" : "R4 remainder"),
          d, e[31:0]);
    end

    // R3 exact busy length
    wr(8'h64, 32'd3);
    busy_reads = 0;
    for (int i = 0; i < 40; i++) begin
      rd(8'h78, d, v);
      if (!d[0]) busy_reads++;
      else break;
    end
    chk("R3 busy cycles", busy_reads, 32'd33);

    // R3 R2 restart with a signed divisor mid-divide: 100 / -7
    wr(8'h60, 32'd100);
    idle(10);
    wr(8'h6C, 32'hFFFFFFF9);
    wait_ready();
    rd(8'h70, d, v); chk("R3 restart quotient", d, 32'hFFFFFFF2);
    rd(8'h74, d, v); chk("R2 restart remainder", d, 32'd2);

    // R8 dirty behaviour
    rd(8'h78, d, v); chk("R8 clean after quotient read", d, 32'h1);
    wr(8'h78, 32'hFFFFFFFF);
    rd(8'h78, d, v); chk("R9 status write ignored", d, 32'h1);
    wr(8'h64, 32'd5);
    wait_ready();
    rd(8'h78, d, v); chk("R8 dirty after operand write", d, 32'h3);
    rd(8'h74, d, v);
    rd(8'h78, d, v); chk("R8 remainder read keeps dirty", d, 32'h3);
    rd(8'h70, d, v);
    rd(8'h78, d, v); chk("R8 quotient read clears", d, 32'h1);

    // R7 abort by result writes
    wr(8'h60, 32'd1000);
    idle(5);
    wr(8'h70, 32'h00001234);
    rd(8'h78, d, v); chk("R7 ready and dirty", d, 32'h3);
    wr(8'h74, 32'h00000055);
    idle(45);
    rd(8'h74, d, v); chk("R7 remainder kept", d, 32'h55);
    rd(8'h70, d, v); chk("R7 quotient kept", d, 32'h1234);
    rd(8'h78, d, v); chk("R9 status layout", d, 32'h1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule